// File: doc/BRIEF.md
# Grouped Timer Interrupt Vector Controller

This block gathers the five interrupt events of a multifunction timer (overflow/underflow, compare 0, compare 1, capture 0, capture 1). It holds each event in a pending flag until software clears it. It gates the flags with a per-source enable and a global enable. It then presents a single interrupt request together with an 8-bit vector. The vector joins a 5-bit base written by software with a 3-bit code for the winning source group. The code also encodes the fixed priority: the capture group wins over the compare group, and the compare group wins over overflow/underflow.

Compare 0 and capture 0 each have a sticky overrun flag. The flag records a new event that arrives while that source is still pending. Either of these two sources can be switched to DMA mode. In DMA mode its pending flag is set by the DMA end-of-block pulse, and its raw event is ignored.

Top module: `tivc_irq_vec_ctrl`

## Requirements
- R1: After reset, every pending and overrun flag is 0, `irq_o` is 0 and `vec_o` is {`vec_base_i`, 3'b111}.
- R2: A source's pending flag is set one cycle after its event strobe is seen high, when it was low at the previous clock edge. Holding a strobe high sets the flag only once. Bit order of `evt_i`, `pend_o`, `pend_clr_i` and `mask_i[4:0]` is: 0 overflow/underflow, 1 compare 0, 2 compare 1, 3 capture 0, 4 capture 1.
- R3: If a set and a pending clear hit the same flag in the same cycle, the flag stays set.
- R4: A pending clear strobe with no set clears that flag at the next clock edge.
- R5: With `dma_en_i[0]` (compare 0) or `dma_en_i[1]` (capture 0) at 1, that source's flag is set by the matching `eob_i` bit being high in a cycle, and its event strobe is ignored. With DMA mode off, `eob_i` has no effect.
- R6: A set of compare 0 or capture 0 while its flag is already 1 raises `ovr_o[0]` or `ovr_o[1]` respectively one cycle later. This holds even when a clear of that flag arrives in the same cycle.
- R7: An overrun flag stays 1 until its `ovr_clr_i` bit is strobed. A new overrun in the same cycle as the clear wins.
- R8: `irq_o` is 1 in the same cycle exactly when `mask_i[7]` is 1 and some pending flag has its `mask_i` bit at 1 (1 = enabled).
- R9: `vec_o` is {`vec_base_i`, code}. The code is that of the highest enabled pending group: 3'b000 for capture (sources 3,4), 3'b100 for compare (sources 1,2), 3'b110 for overflow/underflow (source 0). The code is 3'b111 when `irq_o` is 0.
- R10: Masking affects only the request. Disabled pending flags remain visible on `pend_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event strobes, one per source |
| eob_i | input | 2 | DMA end-of-block pulses (0 compare 0, 1 capture 0) |
| dma_en_i | input | 2 | DMA mode select (0 compare 0, 1 capture 0) |
| mask_i | input | 8 | Bits 4:0 source enables, bit 7 global enable |
| vec_base_i | input | 5 | Software vector base |
| pend_clr_i | input | 5 | Pending clear strobes |
| ovr_clr_i | input | 2 | Overrun clear strobes |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Interrupt vector |
| pend_o | output | 5 | Pending flags |
| ovr_o | output | 2 | Overrun flags (0 compare 0, 1 capture 0) |

## Verification
Directed patterns cover several cases. One raises every source at once and then clears the groups one by one, which shows whether each group maps to the right priority slot and code. Held strobes separate edge sensing from level sensing. Coincident set and clear shows which one wins. Toggling the DMA mode separates the end-of-block path from the raw event path. Random traffic then mixes strobes, clears, masks and bases against a bench model of the flags and the vector. This catches cross-source interference that the directed cases miss.

// File: rtl/tivc_pkg.sv
package tivc_pkg;
  localparam int NSRC    = 5;
  localparam int NGRP    = 3;
  localparam int NCH     = 2;   // channels with DMA mode and overrun
  localparam int CODE_W  = 3;
  localparam int MASK_W  = 8;
  localparam int GEN_BIT = 7;

  localparam int SRC_OVF  = 0;
  localparam int SRC_CMP0 = 1;
  localparam int SRC_CMP1 = 2;
  localparam int SRC_CAP0 = 3;
  localparam int SRC_CAP1 = 4;

  // group index 0 has the highest priority
  localparam int GRP_CAP = 0;
  localparam int GRP_CMP = 1;
  localparam int GRP_OVF = 2;

  localparam logic [CODE_W-1:0] CODE_IDLE = 3'b111;

  function automatic int grp_of(int src);
    case (src)
      SRC_CAP0, SRC_CAP1: return GRP_CAP;
      SRC_CMP0, SRC_CMP1: return GRP_CMP;
      default:            return GRP_OVF;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] grp_code(int grp);
    case (grp)
      GRP_CAP: return 3'b000;
      GRP_CMP: return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  // source served by each DMA/overrun channel
  function automatic int ch_src(int ch);
    return (ch == 0) ? SRC_CMP0 : SRC_CAP0;
  endfunction

  // channel of a source, -1 when it has none
  function automatic int src_ch(int src);
    case (src)
      SRC_CMP0: return 0;
      SRC_CAP0: return 1;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/tivc_trig.sv
module tivc_trig
  import tivc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NCH-1:0]  eob_i,
  input  logic [NCH-1:0]  dma_en_i,
  output logic [NSRC-1:0] set_o
);
  logic [NSRC-1:0] evt_q;
  logic [NSRC-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  assign rise = evt_i & ~evt_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (src_ch(k) >= 0) begin : g_dma
      localparam int CH = src_ch(k);
      assign set_o[k] = dma_en_i[CH] ? eob_i[CH] : rise[k];
    end else begin : g_raw
      assign set_o[k] = rise[k];
    end
  end
endmodule

// File: rtl/tivc_flags.sv
module tivc_flags
  import tivc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] pend_clr_i,
  input  logic [NCH-1:0]  ovr_clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NCH-1:0]  ovr_o
);
  logic [NSRC-1:0] pend_q;
  logic [NCH-1:0]  ovr_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr_i) | set_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ovr
    localparam int S = ch_src(c);
    logic hit;
    assign hit = set_i[S] & pend_q[S];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ovr_q[c] <= 1'b0;
      else         ovr_q[c] <= (ovr_q[c] & ~ovr_clr_i[c]) | hit;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/tivc_arb.sv
module tivc_arb
  import tivc_pkg::*;
#(
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + CODE_W
) (
  input  logic [NSRC-1:0]   pend_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NSRC-1:0]   live;
  logic [NGRP-1:0]   grp_hit;
  logic [CODE_W-1:0] code;
  logic              unused_mask;

  assign live        = pend_i & mask_i[NSRC-1:0] & {NSRC{mask_i[GEN_BIT]}};
  assign unused_mask = ^mask_i[GEN_BIT-1:NSRC];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [NSRC-1:0] member;
    for (genvar k = 0; k < NSRC; k++) begin : g_mem
      assign member[k] = (grp_of(k) == g);
    end
    assign grp_hit[g] = |(live & member);
  end

  always_comb begin
    code = CODE_IDLE;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_hit[g]) code = grp_code(g);
    end
  end

  assign irq_o = |grp_hit;
  assign vec_o = {base_i, code};
endmodule

// File: rtl/tivc_irq_vec_ctrl.sv
module tivc_irq_vec_ctrl
  import tivc_pkg::*;
#(
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [NCH-1:0]    eob_i,
  input  logic [NCH-1:0]    dma_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic [NSRC-1:0]   pend_clr_i,
  input  logic [NCH-1:0]    ovr_clr_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NSRC-1:0]   pend_o,
  output logic [NCH-1:0]    ovr_o
);
  logic [NSRC-1:0] set_w;

  tivc_trig u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .eob_i    (eob_i),
    .dma_en_i (dma_en_i),
    .set_o    (set_w)
  );

  tivc_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_w),
    .pend_clr_i (pend_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .pend_o     (pend_o),
    .ovr_o      (ovr_o)
  );

  tivc_arb #(.BASE_W(BASE_W)) u_arb (
    .pend_i (pend_o),
    .mask_i (mask_i),
    .base_i (vec_base_i),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );
endmodule

// File: rtl/tivc_chk.sv
module tivc_chk
  import tivc_pkg::*;
#(
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   set_i,
  input logic [NSRC-1:0]   pend_o,
  input logic [NSRC-1:0]   pend_clr_i,
  input logic [NCH-1:0]    ovr_o,
  input logic [NCH-1:0]    ovr_clr_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [BASE_W-1:0] vec_base_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o
);
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_clr_i & ~set_i) != '0) |=> ((pend_o & $past(pend_clr_i & ~set_i)) == '0));

  a_r6_ovr_cmp0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[SRC_CMP0] && pend_o[SRC_CMP0]) |=> ovr_o[0]);

  a_r6_ovr_cap0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[SRC_CAP0] && pend_o[SRC_CAP0]) |=> ovr_o[1]);

  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o[0] && !ovr_clr_i[0]) |=> ovr_o[0]);

  a_r8_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_i[GEN_BIT] |-> !irq_o);

  a_r9_vec_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[VEC_W-1:CODE_W] == vec_base_i));

  a_r9_cap_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i[GEN_BIT] && (pend_o[SRC_CAP0] && mask_i[SRC_CAP0])) |-> (vec_o[CODE_W-1:0] == 3'b000));
endmodule

bind tivc_irq_vec_ctrl tivc_chk #(.BASE_W(BASE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_i      (set_w),
  .pend_o     (pend_o),
  .pend_clr_i (pend_clr_i),
  .ovr_o      (ovr_o),
  .ovr_clr_i  (ovr_clr_i),
  .mask_i     (mask_i),
  .vec_base_i (vec_base_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o)
);

// File: tb/tivc_irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module tivc_irq_vec_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt = '0;
  logic [1:0] eob = '0;
  logic [1:0] dma_en = '0;
  logic [7:0] mask = 8'h9F;
  logic [4:0] base = 5'h15;
  logic [4:0] pclr = '0;
  logic [1:0] oclr = '0;
  logic       irq;
  logic [7:0] vec;
  logic [4:0] pend;
  logic [1:0] ovr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] m_pend = '0;
  logic [1:0] m_ovr = '0;
  logic [4:0] m_prev = '0;

  always #5 clk = ~clk;

  tivc_irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .eob_i(eob), .dma_en_i(dma_en),
    .mask_i(mask), .vec_base_i(base), .pend_clr_i(pclr), .ovr_clr_i(oclr),
    .irq_o(irq), .vec_o(vec), .pend_o(pend), .ovr_o(ovr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq(logic [4:0] p, logic [7:0] m);
    return m[7] && ((p & m[4:0]) != 0);
  endfunction

  function automatic logic [7:0] exp_vec(logic [4:0] p, logic [7:0] m, logic [4:0] b);
    logic [4:0] l;
    l = p & m[4:0] & {5{m[7]}};
    if (l[3] | l[4]) return {b, 3'b000};
    if (l[1] | l[2]) return {b, 3'b100};
    if (l[0])        return {b, 3'b110};
    return {b, 3'b111};
  endfunction

  task automatic check_all();
    chk("R2 R3 R4 pend", 32'(pend), 32'(m_pend));
    chk("R6 R7 ovr", 32'(ovr), 32'(m_ovr));
    chk("R8 irq", 32'(irq), 32'(exp_irq(m_pend, mask)));
    chk("R9 vec", 32'(vec), 32'(exp_vec(m_pend, mask, base)));
  endtask

  task automatic tick();
    logic [4:0] s;
    logic [4:0] np;
    logic [1:0] no;
    s = evt & ~m_prev;
    if (dma_en[0]) s[1] = eob[0];
    if (dma_en[1]) s[3] = eob[1];
    np = (m_pend & ~pclr) | s;
    no[0] = (m_ovr[0] & ~oclr[0]) | (s[1] & m_pend[1]);
    no[1] = (m_ovr[1] & ~oclr[1]) | (s[3] & m_pend[3]);
    @(posedge clk);
    @(negedge clk);
    m_pend = np;
    m_ovr = no;
    m_prev = evt;
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 pend", 32'(pend), 0);
    chk("R1 ovr", 32'(ovr), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vec", 32'(vec), 32'({5'h15, 3'b111}));
    rst_n = 1'b1;
    tick();

    // R2 edge sensing, held level sets only once
    evt[2] = 1; tick();
    chk("R2 set", 32'(pend[2]), 1);
    pclr[2] = 1; tick(); pclr = '0;
    tick();
    chk("R2 held level", 32'(pend[2]), 0);

    // R3 set with clear in same cycle
    evt[2] = 0; tick();
    evt[2] = 1; pclr[2] = 1; tick(); pclr = '0;
    chk("R3 set wins", 32'(pend[2]), 1);
    evt[2] = 0; pclr[2] = 1; tick(); pclr = '0;
    chk("R4 cleared", 32'(pend[2]), 0);

    // R6 overrun on compare 0 even with same-cycle clear
    evt[1] = 1; tick();
    evt[1] = 0; tick();
    evt[1] = 1; pclr[1] = 1; tick(); pclr = '0;
    chk("R6 overrun cmp0", 32'(ovr[0]), 1);
    evt[1] = 0; tick(); tick();
    chk("R7 sticky", 32'(ovr[0]), 1);
    oclr[0] = 1; tick(); oclr = '0;
    chk("R7 cleared", 32'(ovr[0]), 0);
    pclr = 5'h1F; tick(); pclr = '0;

    // R5 DMA mode
    dma_en = 2'b11; evt[3] = 1; tick();
    chk("R5 raw ignored", 32'(pend[3]), 0);
    eob[1] = 1; tick(); eob = '0;
    chk("R5 eob sets", 32'(pend[3]), 1);
    evt[3] = 0; dma_en = '0; pclr = 5'h1F; tick(); pclr = '0;
    eob[0] = 1; tick(); eob = '0;
    chk("R5 eob ignored off", 32'(pend[1]), 0);

    // R9 priority walk
    evt = 5'h1F; tick();
    chk("R9 capture", 32'(vec[2:0]), 32'(3'b000));
    pclr = 5'b11000; tick(); pclr = '0;
    chk("R9 compare", 32'(vec[2:0]), 32'(3'b100));
    pclr = 5'b00110; tick(); pclr = '0;
    chk("R9 overflow", 32'(vec[2:0]), 32'(3'b110));
    pclr = 5'b00001; tick(); pclr = '0;
    chk("R9 idle", 32'(vec[2:0]), 32'(3'b111));
    evt = '0; tick();

    // R8 gating, R10 visibility
    evt[0] = 1; tick(); evt = '0;
    mask = 8'h1F; #1;
    chk("R8 global off", 32'(irq), 0);
    chk("R10 still pending", 32'(pend[0]), 1);
    mask = 8'h9E; #1;
    chk("R8 source off", 32'(irq), 0);
    mask = 8'h9F; #1;
    chk("R8 enabled", 32'(irq), 1);
    chk("R9 vec full", 32'(vec), 32'({5'h15, 3'b110}));
    tick();

    // random traffic
    for (int i = 0; i < 600; i++) begin
      evt    = 5'($urandom);
      eob    = 2'($urandom);
      dma_en = (($urandom % 8) == 0) ? 2'($urandom) : dma_en;
      pclr   = 5'($urandom) & 5'($urandom);
      oclr   = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      mask   = {(($urandom % 5) != 0), 2'($urandom), 5'($urandom)};
      base   = 5'($urandom);
      #1;
      chk("R8 irq pre", 32'(irq), 32'(exp_irq(m_pend, mask)));
      chk("R9 vec pre", 32'(vec), 32'(exp_vec(m_pend, mask, base)));
      tick();
    end
    finish_run();
  end
endmodule